// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block is a purely combinational comparator for IEEE-754 binary32 and binary64 values. It takes two operands, or one operand and an implied +0.0, and reduces the comparison to one of four outcomes: equal, less, greater or unordered. Each outcome maps to a fixed four-bit N/Z/C/V condition pattern. The block also raises an invalid-operation pulse, which the surrounding status logic ORs into its cumulative exception register.

Controls select the precision, replace the second operand with +0.0, choose the NaN policy and enable flushing of subnormal inputs to signed zero. There are two NaN policies. In the quiet policy, only a signaling NaN raises invalid. In the signalling policy, every unordered result raises it.

The four outcomes are listed here as the block's only states. They are held in the enumerated type `cmp_outcome_t`: `CMP_EQ`, `CMP_LT`, `CMP_GT`, `CMP_UN`. There is no clocked state and no transition between outcomes. The outcome follows the inputs directly.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: Equal operands give flags {N,Z,C,V} = 0110.
- R2: When the first operand is less than the second, the flags are {N,Z,C,V} = 1000.
- R3: When the first operand is greater than the second, the flags are {N,Z,C,V} = 0010 (+infinity is greater than every finite value).
- R4: When either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and the flags are {N,Z,C,V} = 0011.
- R5: +0 and -0 compare as equal.
- R6: Non-NaN values are ordered by sign and then by magnitude. When both operands are negative, the larger magnitude is the smaller value.
- R7: A NaN whose quiet bit (fraction MSB: bit 22 for single, bit 51 for double) is clear is signaling. When `any_nan_inv`=0, `invalid` is 1 exactly when at least one operand is a signaling NaN. A quiet NaN leaves it 0.
- R8: When `any_nan_inv`=1, every unordered result sets `invalid`. An ordered result never sets `invalid` in either policy.
- R9: When `ftz_en`=1, a subnormal operand (exponent zero, fraction nonzero) compares as a zero of its own sign. When `ftz_en`=0, it compares by its value.
- R10: When `zero_sel`=1, the second operand is +0.0 and the value on `op_b` has no effect on any output.
- R11: When `dbl_sel`=0, only bits [31:0] of each operand are used as binary32. When `dbl_sel`=1, all 64 bits are used as binary64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand (binary32 in [31:0] or binary64) |
| op_b | input | 64 | Second operand (binary32 in [31:0] or binary64) |
| dbl_sel | input | 1 | 1 = binary64, 0 = binary32 |
| zero_sel | input | 1 | 1 = compare op_a against +0.0 |
| any_nan_inv | input | 1 | 1 = any NaN raises invalid |
| ftz_en | input | 1 | 1 = flush subnormal inputs to signed zero |
| flag_n | output | 1 | Negative / less-than flag |
| flag_z | output | 1 | Zero / equal flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow / unordered flag |
| invalid | output | 1 | Invalid-operation pulse |

## Verification
The hardest situation to separate is a NaN whose payload sits only in the low fraction bits, with the quiet bit clear. An encoding that is also almost the infinity pattern must still be seen as signaling. The stimulus drives 0x7F800001 and 0x7FF0000000000001 against ordinary numbers, and also drives a quiet NaN that carries extra payload, so that a misplaced quiet-bit test shows up in `invalid`. Subnormals are applied with flushing both off and on, with each sign. This shows that the flush keeps the sign but erases the magnitude.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    localparam int SP_EXP_W  = 8;
    localparam int SP_FRAC_W = 23;
    localparam int DP_EXP_W  = 11;
    localparam int DP_FRAC_W = 52;

    typedef enum logic [1:0] {
        CMP_EQ = 2'd0,
        CMP_LT = 2'd1,
        CMP_GT = 2'd2,
        CMP_UN = 2'd3
    } cmp_outcome_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int MAG_W  = EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    input  logic              ftz_en,
    output logic              sign,
    output logic              is_nan,
    output logic              is_snan,
    output logic              is_zero,
    output logic [MAG_W-1:0]  mag
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    always_comb begin
        sign    = word[WORD_W-1];
        exp_f   = word[WORD_W-2:FRAC_W];
        frac_f  = word[FRAC_W-1:0];
        exp_max = &exp_f;
        exp_min = ~|exp_f;
        frac_nz = |frac_f;
        is_nan  = exp_max && frac_nz;
        // quiet bit is the fraction MSB
        is_snan = is_nan && !frac_f[FRAC_W-1];
        // subnormals become signed zero only when flushing is on
        is_zero = exp_min && (!frac_nz || ftz_en);
        mag     = is_zero ? '0 : word[MAG_W-1:0];
    end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
    import fpcmp_pkg::*;
#(
    parameter int MAG_W = 63
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic             zero_a,
    input  logic             zero_b,
    input  logic             nan_any,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    output cmp_outcome_t     outcome
);
    logic mag_lt;
    logic mag_eq;

    always_comb begin
        mag_lt = mag_a < mag_b;
        mag_eq = mag_a == mag_b;
        if (nan_any) begin
            outcome = CMP_UN;
        end else if (zero_a && zero_b) begin
            outcome = CMP_EQ;
        end else if (sign_a != sign_b) begin
            outcome = sign_a ? CMP_LT : CMP_GT;
        end else if (mag_eq) begin
            outcome = CMP_EQ;
        end else if (sign_a) begin
            outcome = mag_lt ? CMP_GT : CMP_LT;
        end else begin
            outcome = mag_lt ? CMP_LT : CMP_GT;
        end
    end
endmodule

// File: rtl/fpcmp_flags.sv
module fpcmp_flags
    import fpcmp_pkg::*;
(
    input  cmp_outcome_t outcome,
    input  logic         snan_any,
    input  logic         any_nan_inv,
    output logic [3:0]   nzcv,
    output logic         invalid
);
    always_comb begin
        nzcv    = 4'b0000;
        invalid = 1'b0;
        unique case (outcome)
            CMP_EQ: nzcv = 4'b0110;
            CMP_LT: nzcv = 4'b1000;
            CMP_GT: nzcv = 4'b0010;
            CMP_UN: begin
                nzcv    = 4'b0011;
                invalid = any_nan_inv || snan_any;
            end
            default: nzcv = 4'b0000;
        endcase
    end
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
    import fpcmp_pkg::*;
#(
    parameter int SEXP_W  = SP_EXP_W,
    parameter int SFRAC_W = SP_FRAC_W,
    parameter int DEXP_W  = DP_EXP_W,
    parameter int DFRAC_W = DP_FRAC_W,
    localparam int SW_W   = 1 + SEXP_W + SFRAC_W,
    localparam int DW_W   = 1 + DEXP_W + DFRAC_W,
    localparam int SMAG_W = SEXP_W + SFRAC_W,
    localparam int DMAG_W = DEXP_W + DFRAC_W
) (
    input  logic [DW_W-1:0] op_a,
    input  logic [DW_W-1:0] op_b,
    input  logic            dbl_sel,
    input  logic            zero_sel,
    input  logic            any_nan_inv,
    input  logic            ftz_en,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flag_v,
    output logic            invalid
);
    logic [DW_W-1:0]   opnd [2];
    logic              sgn  [2];
    logic              nan  [2];
    logic              snan [2];
    logic              zro  [2];
    logic [DMAG_W-1:0] mag  [2];

    always_comb begin
        opnd[0] = op_a;
        opnd[1] = zero_sel ? '0 : op_b;
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
        logic              s_sgn, s_nan, s_snan, s_zro;
        logic [SMAG_W-1:0] s_mag;
        logic              d_sgn, d_nan, d_snan, d_zro;
        logic [DMAG_W-1:0] d_mag;

        fpcmp_classify #(.EXP_W(SEXP_W), .FRAC_W(SFRAC_W)) u_sp (
            .word(opnd[gi][SW_W-1:0]), .ftz_en(ftz_en),
            .sign(s_sgn), .is_nan(s_nan), .is_snan(s_snan),
            .is_zero(s_zro), .mag(s_mag)
        );
        fpcmp_classify #(.EXP_W(DEXP_W), .FRAC_W(DFRAC_W)) u_dp (
            .word(opnd[gi]), .ftz_en(ftz_en),
            .sign(d_sgn), .is_nan(d_nan), .is_snan(d_snan),
            .is_zero(d_zro), .mag(d_mag)
        );

        always_comb begin
            sgn[gi]  = dbl_sel ? d_sgn  : s_sgn;
            nan[gi]  = dbl_sel ? d_nan  : s_nan;
            snan[gi] = dbl_sel ? d_snan : s_snan;
            zro[gi]  = dbl_sel ? d_zro  : s_zro;
            mag[gi]  = dbl_sel ? d_mag  : {{(DMAG_W-SMAG_W){1'b0}}, s_mag};
        end
    end

    cmp_outcome_t outcome;
    logic [3:0]   nzcv;

    fpcmp_order #(.MAG_W(DMAG_W)) u_order (
        .sign_a(sgn[0]), .sign_b(sgn[1]),
        .zero_a(zro[0]), .zero_b(zro[1]),
        .nan_any(nan[0] || nan[1]),
        .mag_a(mag[0]), .mag_b(mag[1]),
        .outcome(outcome)
    );

    fpcmp_flags u_flags (
        .outcome(outcome),
        .snan_any(snan[0] || snan[1]),
        .any_nan_inv(any_nan_inv),
        .nzcv(nzcv),
        .invalid(invalid)
    );

    always_comb begin
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
    end

    always_comb begin
        AST_EQ_PATTERN: assert (!flag_z || (flag_c && !flag_n && !flag_v))
            else $error("Z set without C"); // R1
        AST_LT_NO_CARRY: assert (!(flag_n && flag_c))
            else $error("N and C both set"); // R2
        AST_UNORD_PATTERN: assert (!flag_v || (flag_c && !flag_z && !flag_n))
            else $error("bad unordered pattern"); // R4
        AST_ZEROS_EQUAL: assert (!(zro[0] && zro[1] && !nan[0] && !nan[1]) || flag_z)
            else $error("two zeros not equal"); // R5
        AST_SNAN_RAISES: assert (!(snan[0] || snan[1]) || invalid)
            else $error("signaling NaN without invalid"); // R7
        AST_INVALID_UNORD: assert (!invalid || flag_v)
            else $error("invalid on ordered result"); // R8
    end
endmodule

// File: tb/fpcmp_flag_unit_tb.sv
module fpcmp_flag_unit_tb;
    logic        clk = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        dbl_sel = 1'b0;
    logic        zero_sel = 1'b0;
    logic        any_nan_inv = 1'b0;
    logic        ftz_en = 1'b0;
    logic        flag_n, flag_z, flag_c, flag_v, invalid;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    fpcmp_flag_unit u_dut (
        .op_a(op_a), .op_b(op_b), .dbl_sel(dbl_sel), .zero_sel(zero_sel),
        .any_nan_inv(any_nan_inv), .ftz_en(ftz_en),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .invalid(invalid)
    );

    localparam logic [3:0] EQ = 4'b0110, LT = 4'b1000, GT = 4'b0010, UN = 4'b0011;

    task automatic run(input string tag, input logic [63:0] a, input logic [63:0] b,
                       input logic dbl, input logic zs, input logic anyn, input logic ftz,
                       input logic [3:0] exp_f, input logic exp_inv);
        @(posedge clk);
        op_a = a; op_b = b; dbl_sel = dbl; zero_sel = zs;
        any_nan_inv = anyn; ftz_en = ftz;
        @(negedge clk);
        checks++;
        if ({flag_n, flag_z, flag_c, flag_v} !== exp_f || invalid !== exp_inv) begin
            errors++;
            $display("FAIL %s: nzcv=%b inv=%b expected nzcv=%b inv=%b",
                     tag, {flag_n, flag_z, flag_c, flag_v}, invalid, exp_f, exp_inv);
        end
    endtask

    task automatic t_basic_order();
        run("R1 single 1.0==1.0", 64'h3F800000, 64'h3F800000, 0, 0, 0, 0, EQ, 0);
        run("R2 single 1.0<2.0",  64'h3F800000, 64'h40000000, 0, 0, 0, 0, LT, 0);
        run("R3 single 2.0>1.0",  64'h40000000, 64'h3F800000, 0, 0, 0, 0, GT, 0);
        run("R3 single inf>2.0",  64'h7F800000, 64'h40000000, 0, 0, 0, 0, GT, 0);
    endtask

    task automatic t_signs();
        run("R6 -2.0<-1.0", 64'hC0000000, 64'hBF800000, 0, 0, 0, 0, LT, 0);
        run("R6 -1.0>-2.0", 64'hBF800000, 64'hC0000000, 0, 0, 0, 0, GT, 0);
        run("R6 -1.0<1.0",  64'hBF800000, 64'h3F800000, 0, 0, 0, 0, LT, 0);
        run("R5 +0==-0",    64'h00000000, 64'h80000000, 0, 0, 0, 0, EQ, 0);
        run("R5 -0==+0 dbl", 64'h8000000000000000, 64'h0, 1, 0, 0, 0, EQ, 0);
    endtask

    task automatic t_nans();
        run("R4 R7 qNaN vs 1.0", 64'h7FC00000, 64'h3F800000, 0, 0, 0, 0, UN, 0);
        run("R7 qNaN payload",   64'h3F800000, 64'h7FC00001, 0, 0, 0, 0, UN, 0);
        run("R7 sNaN single",    64'h7F800001, 64'h3F800000, 0, 0, 0, 0, UN, 1);
        run("R7 sNaN double",    64'h3FF0000000000000, 64'h7FF0000000000001, 1, 0, 0, 0, UN, 1);
        run("R7 qNaN double",    64'h7FF8000000000000, 64'h3FF0000000000000, 1, 0, 0, 0, UN, 0);
        run("R8 any-NaN qNaN",   64'h7FC00000, 64'h3F800000, 0, 0, 1, 0, UN, 1);
        run("R8 any-NaN ordered", 64'h3F800000, 64'h40000000, 0, 0, 1, 0, LT, 0);
    endtask

    task automatic t_double();
        run("R11 dbl 1.0<2.0",  64'h3FF0000000000000, 64'h4000000000000000, 1, 0, 0, 0, LT, 0);
        run("R11 dbl -3.0<1.0", 64'hC008000000000000, 64'h3FF0000000000000, 1, 0, 0, 0, LT, 0);
        run("R11 single ignores upper", 64'hFFFFFFFF_3F800000, 64'h12345678_40000000, 0, 0, 0, 0, LT, 0);
    endtask

    task automatic t_flush();
        run("R9 denorm>0 no ftz",  64'h00000001, 64'h0, 0, 0, 0, 0, GT, 0);
        run("R9 denorm==0 ftz",    64'h00000001, 64'h0, 0, 0, 0, 1, EQ, 0);
        run("R9 -denorm<0 no ftz", 64'h80000001, 64'h0, 0, 0, 0, 0, LT, 0);
        run("R9 -denorm==0 ftz",   64'h80000001, 64'h0, 0, 0, 0, 1, EQ, 0);
        run("R9 dbl denorm ftz",   64'h0000000000000001, 64'h0, 1, 0, 0, 1, EQ, 0);
    endtask

    task automatic t_zero_sel();
        run("R10 1.0 vs +0 sNaN on b", 64'h3F800000, 64'h7F800001, 0, 1, 0, 0, GT, 0);
        run("R10 -1.0 vs +0",          64'hBF800000, 64'h3F800000, 0, 1, 0, 0, LT, 0);
        run("R10 -0 vs +0 dbl",        64'h8000000000000000, 64'h7FF0000000000001, 1, 1, 1, 0, EQ, 0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if ({flag_n, flag_z, flag_c, flag_v, invalid} !== 5'b01100) begin
            errors++;
            $display("FAIL R1 idle zeros: got %b expected 01100",
                     {flag_n, flag_z, flag_c, flag_v, invalid});
        end
        t_basic_order();
        t_signs();
        t_nans();
        t_double();
        t_flush();
        t_zero_sel();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: run did not complete");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule